// File: doc/BRIEF.md
# NAND ECC Readout and Interrupt Unit

This block sits next to the transfer engine of a NAND flash controller. It latches the error-correction result of a page transfer into six byte slots, which software then reads one byte at a time through a byte-wide register port. The six bytes form two 3-byte codes, handed out in order. Any write to that port rewinds the readout and sends a one-cycle reset strobe to the ECC engine. Stored bytes are kept.

The block also holds five sticky event flags. It derives two of them from edges. A falling edge of the engine's run status marks the end of a transfer. A change of the card-detect level, in either direction, marks a card transition; this level passes through a synchronizer first. The other three flags come from single-cycle pulses: ECC ready, ECC error and illegal operation. Hardware only sets the flags and software only clears them. When a set and a clear meet in the same cycle, the set wins. Interrupt masking is left to the consumer of `flags_o` / `irq_o`.

Top module: `nand_ecc_irq_unit`

## Requirements
- R1: After reset every byte slot, the readout position and all flags are 0, `ecc_rst_o` is low, and a read of either address returns 0x00.
- R2: A one-cycle `ecc_rdy_i` pulse stores byte k = `ecc_code_i[8k+7:8k]` for k = 0..5 and rewinds the readout to byte 0. It also sets the ready flag (bit 2), which is visible after the same clock edge.
- R3: Reads at address 0 return bytes 0,1,2 (first code) then 3,4,5 (second code). The position advances by one per read cycle, wraps to byte 0 after byte 5, and does not move on cycles without a read.
- R4: Any write at address 0 rewinds the readout to byte 0, leaves the stored bytes unchanged, and drives `ecc_rst_o` high for exactly the one cycle after the write edge.
- R5: The stop flag (bit 0) sets at the edge after `run_i` falls from 1 to 0. A rising `run_i` does not set it.
- R6: The card-transition flag (bit 4) sets on both rising and falling changes of `card_det_i`. It is visible SYNC_STAGES+1 edges after the change (3 with the default).
- R7: A one-cycle `ecc_err_i` pulse sets bit 1 and a one-cycle `illegal_i` pulse sets bit 3, each visible after that edge.
- R8: Flags are sticky. A write at address 1 clears each flag whose data bit is 0 and keeps each flag whose data bit is 1.
- R9: A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R10: Bits 7 to 5 of a read at address 1 are always 0, and writing 1s to them has no effect.
- R11: `irq_o` is high exactly while at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Transfer engine running status |
| ecc_rdy_i | input | 1 | One-cycle pulse: ECC value valid |
| ecc_err_i | input | 1 | One-cycle pulse: bad ECC seen |
| illegal_i | input | 1 | One-cycle pulse: illegal operation |
| card_det_i | input | 1 | Card-detect level, asynchronous |
| ecc_code_i | input | 48 | Six ECC bytes, byte 0 in bits 7:0 |
| addr_i | input | 1 | Register select: 0 ECC data, 1 flags |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (advances ECC readout) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ecc_rst_o | output | 1 | One-cycle reset strobe to the ECC engine |
| flags_o | output | 5 | Flag vector: 0 stop, 1 err, 2 ready, 3 illegal, 4 card |
| irq_o | output | 1 | OR of all flags |

## Verification
Read data is combinational, so the bench samples `rdata_o` in the same cycle it raises `rd_i`, and expects the next byte in the next read cycle. Pulse flags, the stop flag and `ecc_rst_o` change at the first edge after their cause, so the bench checks them at the falling edge after exactly one rising edge. The card-transition flag needs three edges: two synchronizer stages and one edge-detect register. The bench checks that the flag is still clear after two edges and set after the third.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int FLAG_W = 5;

  typedef enum logic {
    A_ECC  = 1'b0,
    A_FLAG = 1'b1
  } reg_addr_e;

  // bit order is software visible: stop is bit 0, card is bit 4
  typedef struct packed {
    logic card;
    logic illegal;
    logic ecc_rdy;
    logic ecc_err;
    logic stop;
  } flag_vec_t;

endpackage

// File: rtl/nand_evt_detect.sv
module nand_evt_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic card_det_i,
  output logic stop_o,
  output logic card_tgl_o
);

  logic run_q;
  logic card_s;
  logic card_prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign card_s = card_det_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= '0;
        end else begin
          chain_q[0] <= card_det_i;
          for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
      end
      assign card_s = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      card_prev_q <= 1'b0;
    end else begin
      run_q       <= run_i;
      card_prev_q <= card_s;
    end
  end

  assign stop_o     = run_q & ~run_i;
  assign card_tgl_o = card_s ^ card_prev_q;

  // R5: stop event only on a 1 -> 0 change of run
  a_r5_stop_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> ($past(run_i) && !run_i));

endmodule

// File: rtl/nand_ecc_fifo.sv
module nand_ecc_fifo #(
  parameter int ECC_BYTES = 6,
  parameter int DATA_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [ECC_BYTES*DATA_W-1:0] code_i,
  input  logic                        rd_i,
  input  logic                        rewind_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        eng_rst_o
);

  localparam int PTR_W = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ECC_BYTES - 1);

  logic [DATA_W-1:0] slot_q [ECC_BYTES];
  logic [PTR_W-1:0]  ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ECC_BYTES; i++) slot_q[i] <= '0;
      ptr_q     <= '0;
      eng_rst_o <= 1'b0;
    end else begin
      eng_rst_o <= rewind_i;
      if (load_i) begin
        for (int i = 0; i < ECC_BYTES; i++) slot_q[i] <= code_i[i*DATA_W +: DATA_W];
      end
      if (load_i || rewind_i) ptr_q <= '0;
      else if (rd_i)          ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign rdata_o = slot_q[ptr_q];

  // R3: position never leaves the slot range
  a_r3_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);

  // R3: last byte read wraps to byte 0
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !load_i && !rewind_i && ptr_q == LAST) |=> ptr_q == '0);

  // R3: idle cycles hold position
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !load_i && !rewind_i) |=> $stable(ptr_q));

  // R4: rewind restarts readout and strobes engine reset
  a_r4_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> (ptr_q == '0 && eng_rst_o));

  // R2: load presents byte 0 of the new code
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rdata_o == $past(code_i[DATA_W-1:0])));

endmodule

// File: rtl/nand_irq_flags.sv
module nand_irq_flags #(
  parameter int FLAG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flags_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (wr_i ? (flags_o & wdata_i) : flags_o) | set_i;
  end

  // R9: a set always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R8: without a write, nothing clears
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R8: data bit 1 keeps a set flag
  a_r8_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((flags_o & $past(flags_o & wdata_i)) == $past(flags_o & wdata_i)));

  // R8: only hardware raises a flag
  a_r8_only_hw_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));

endmodule

// File: rtl/nand_ecc_irq_unit.sv
module nand_ecc_irq_unit
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ECC_BYTES   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic                        ecc_rdy_i,
  input  logic                        ecc_err_i,
  input  logic                        illegal_i,
  input  logic                        card_det_i,
  input  logic [ECC_BYTES*DATA_W-1:0] ecc_code_i,
  input  logic                        addr_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        ecc_rst_o,
  output logic [FLAG_W-1:0]           flags_o,
  output logic                        irq_o
);

  logic      ecc_sel, flag_sel;
  logic      stop_evt, card_evt;
  flag_vec_t set_vec;
  logic [DATA_W-1:0] ecc_byte;
  logic      unused_wdata;

  assign ecc_sel  = (reg_addr_e'(addr_i) == A_ECC);
  assign flag_sel = (reg_addr_e'(addr_i) == A_FLAG);

  nand_evt_detect #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .card_det_i (card_det_i),
    .stop_o     (stop_evt),
    .card_tgl_o (card_evt)
  );

  nand_ecc_fifo #(.ECC_BYTES(ECC_BYTES), .DATA_W(DATA_W)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ecc_rdy_i),
    .code_i    (ecc_code_i),
    .rd_i      (rd_i && ecc_sel),
    .rewind_i  (wr_i && ecc_sel),
    .rdata_o   (ecc_byte),
    .eng_rst_o (ecc_rst_o)
  );

  always_comb begin
    set_vec         = '0;
    set_vec.stop    = stop_evt;
    set_vec.ecc_err = ecc_err_i;
    set_vec.ecc_rdy = ecc_rdy_i;
    set_vec.illegal = illegal_i;
    set_vec.card    = card_evt;
  end

  nand_irq_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .wr_i    (wr_i && flag_sel),
    .wdata_i (wdata_i[FLAG_W-1:0]),
    .flags_o (flags_o)
  );

  // reserved write bits are dropped
  assign unused_wdata = ^wdata_i[DATA_W-1:FLAG_W];

  assign rdata_o = ecc_sel ? ecc_byte : DATA_W'(flags_o);
  assign irq_o   = |flags_o;

  // R10: reserved bits read as zero
  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_sel |-> (rdata_o[DATA_W-1:FLAG_W] == '0));

  // R5: stop flag rises only after run fell
  a_r5_stop_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> ($past(run_i, 2) && !$past(run_i)));

  // R7: error flag rises only after an error pulse
  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[1]) |-> $past(ecc_err_i));

endmodule

// File: tb/nand_ecc_irq_unit_tb_top.sv
module nand_ecc_irq_unit_tb_top;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_LD = 2'd2;
  localparam logic A_E = 1'b0, A_F = 1'b1;

  typedef struct packed {
    logic [1:0] kind;
    logic       addr;
    logic [7:0] data;   // write data or expected read data
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{K_RD, A_F, 8'h00, 4'd1},   // R1 flags clear
    '{K_LD, A_E, 8'h00, 4'd2},   // R2 load
    '{K_RD, A_F, 8'h04, 4'd2},   // R2 ready flag
    '{K_RD, A_E, 8'hA1, 4'd2},   // R2 rewound to byte 0
    '{K_RD, A_E, 8'hB2, 4'd3},   // R3
    '{K_RD, A_E, 8'hC3, 4'd3},
    '{K_RD, A_E, 8'hD4, 4'd3},
    '{K_RD, A_E, 8'hE5, 4'd3},
    '{K_RD, A_E, 8'hF6, 4'd3},
    '{K_RD, A_E, 8'hA1, 4'd3},   // R3 wrap
    '{K_RD, A_E, 8'hB2, 4'd3},
    '{K_WR, A_E, 8'h5A, 4'd4},   // R4 rewind
    '{K_RD, A_E, 8'hA1, 4'd4},
    '{K_WR, A_F, 8'hFB, 4'd8},   // R8 clear ready only
    '{K_RD, A_F, 8'h00, 4'd8},
    '{K_RD, A_E, 8'hB2, 4'd3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0, ecc_rdy_i = 1'b0, ecc_err_i = 1'b0, illegal_i = 1'b0;
  logic        card_det_i = 1'b0;
  logic [47:0] ecc_code_i = 48'hF6E5D4C3B2A1;
  logic        addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic        ecc_rst_o, irq_o;
  logic [4:0]  flags_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  nand_ecc_irq_unit dut_i (
    .clk_i, .rst_ni, .run_i, .ecc_rdy_i, .ecc_err_i, .illegal_i, .card_det_i,
    .ecc_code_i, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .ecc_rst_o,
    .flags_o, .irq_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic bus_rd(input logic a, input logic [7:0] exp, input string req);
    addr_i = a; rd_i = 1'b1;
    #1 chk(req, rdata_o, exp);
    tick();
    rd_i = 1'b0;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
  endtask

  task automatic ld_pulse();
    ecc_rdy_i = 1'b1;
    tick();
    ecc_rdy_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    addr_i = A_E; #1 chk("R1 ecc byte", rdata_o, 8'h00);
    addr_i = A_F; #1 chk("R1 flag reg", rdata_o, 8'h00);
    chk("R1 ecc_rst_o", {7'd0, ecc_rst_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
      case (VECS[i].kind)
        K_RD:    bus_rd(VECS[i].addr, VECS[i].data, tag);
        K_WR:    bus_wr(VECS[i].addr, VECS[i].data);
        default: ld_pulse();
      endcase
    end

    // R3 idle cycles do not advance (position at byte 2)
    repeat (3) tick();
    bus_rd(A_E, 8'hC3, "R3 idle hold");

    // R2 reload mid-stream rewinds
    ecc_code_i = 48'h665544332211;
    ld_pulse();
    bus_rd(A_E, 8'h11, "R2 reload byte0");
    bus_rd(A_E, 8'h22, "R2 reload byte1");

    // R4 strobe lasts one cycle, bytes kept
    bus_wr(A_E, 8'h00);
    chk("R4 strobe high", {7'd0, ecc_rst_o}, 8'h01);
    tick();
    chk("R4 strobe low", {7'd0, ecc_rst_o}, 8'h00);
    bus_rd(A_E, 8'h11, "R4 rewind keeps bytes");

    bus_wr(A_F, 8'h00);
    chk("R11 irq low", {7'd0, irq_o}, 8'h00);

    // R5 stop on fall only
    run_i = 1'b1; tick();
    tick();
    chk("R5 no set on rise", {3'd0, flags_o}, 8'h00);
    run_i = 1'b0; tick();
    chk("R5 stop set", {3'd0, flags_o}, 8'h01);
    chk("R11 irq high", {7'd0, irq_o}, 8'h01);
    bus_wr(A_F, 8'h00);

    // R7 pulses
    ecc_err_i = 1'b1; tick(); ecc_err_i = 1'b0;
    chk("R7 err flag", {3'd0, flags_o}, 8'h02);
    bus_wr(A_F, 8'h00);
    illegal_i = 1'b1; tick(); illegal_i = 1'b0;
    chk("R7 illegal flag", {3'd0, flags_o}, 8'h08);

    // R8 write 1 keeps, R10 reserved
    bus_wr(A_F, 8'hFF);
    chk("R8 one keeps", {3'd0, flags_o}, 8'h08);
    bus_rd(A_F, 8'h08, "R10 reserved read zero");
    bus_wr(A_F, 8'hF7);
    chk("R8 zero clears", {3'd0, flags_o}, 8'h00);
    bus_wr(A_F, 8'hE0);
    bus_rd(A_F, 8'h00, "R10 reserved write ignored");

    // R9 set beats clear
    bus_wr(A_F, 8'h00);
    ecc_err_i = 1'b1;
    ld_pulse();   // ready set by hardware while no clear
    ecc_err_i = 1'b0;
    addr_i = A_F; wdata_i = 8'h00; wr_i = 1'b1; illegal_i = 1'b1;
    tick();
    wr_i = 1'b0; illegal_i = 1'b0;
    chk("R9 set wins", {3'd0, flags_o}, 8'h08);
    bus_wr(A_F, 8'h00);

    // R6 card edges, three-edge latency
    card_det_i = 1'b1;
    tick(); tick();
    chk("R6 rise early", {3'd0, flags_o}, 8'h00);
    tick();
    chk("R6 rise set", {3'd0, flags_o}, 8'h10);
    bus_wr(A_F, 8'hEF);
    chk("R6 cleared", {3'd0, flags_o}, 8'h00);
    card_det_i = 1'b0;
    tick(); tick();
    chk("R6 fall early", {3'd0, flags_o}, 8'h00);
    tick();
    chk("R6 fall set", {3'd0, flags_o}, 8'h10);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule